// File: doc/BRIEF.md
# H-Bridge Polarity-Steered Gate Selector

This block drives the four gates of one H-bridge (legs A and B) without any blanking interval. In each leg only one switch is ever gated from that leg's PWM command. Which switch is used depends on the direction of the load current, and the other switch in the leg stays off. Complementary switching never happens, so shoot-through cannot occur and no dead time has to be inserted.

The current direction is worked out without a current sensor. The block uses four active-low flags that report conduction of the freewheeling diode across each switch. Each flag passes through a synchronizer chain and then a three-sample agreement filter. The filtered flags then update one bridge polarity register, which is kept in the sense of leg A. Leg B always takes the opposite polarity, because its current is the negative of leg A's. While no diode conducts, the stored polarity is kept. If both diodes of one leg report conduction at once, the polarity is also kept and a sticky fault is raised.

Top module: `hbridge_polarity_gate`

## Requirements
- R1: During reset, and after reset until a first polarity has been decided, all four gate outputs and `fault` are low, whatever the PWM inputs do.
- R2: Positive polarity (current out of leg A) is decided when leg A's lower diode conducts or leg B's upper diode conducts. Then `gate_a_hi` = `pwm_a`, `gate_a_lo` = 0, `gate_b_lo` = NOT `pwm_b` and `gate_b_hi` = 0.
- R3: Negative polarity is decided when leg A's upper diode conducts or leg B's lower diode conducts. Then `gate_a_lo` = NOT `pwm_a`, `gate_a_hi` = 0, `gate_b_hi` = `pwm_b` and `gate_b_lo` = 0.
- R4: The upper and lower gates of the same leg are never high in the same cycle.
- R5: Leg B's polarity is always the opposite of leg A's. The same-side gates of both legs (`gate_a_hi`/`gate_b_hi`, `gate_a_lo`/`gate_b_lo`) are never high together.
- R6: While no diode flag conducts, the stored polarity and the selected switches stay unchanged.
- R7: A diode flag (active low, 0 = conducting) takes effect only after it has held for 3 consecutive synchronized samples. A pulse of 2 cycles has no effect. A change held from before clock edge 1 shows at the gates after edge 8.
- R8: If both diodes of one leg conduct together, the polarity is kept and `fault` goes high. `fault` stays high until reset, and later diode evidence still updates the polarity.
- R9: If one leg votes positive while the other votes negative, the polarity is kept and `fault` does not change.
- R10: After a polarity is decided, a PWM input change appears at the selected gate after one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_a | input | 1 | PWM command, leg A |
| pwm_b | input | 1 | PWM command, leg B |
| diode_a_hi_n | input | 1 | Leg A upper diode conducting, active low |
| diode_a_lo_n | input | 1 | Leg A lower diode conducting, active low |
| diode_b_hi_n | input | 1 | Leg B upper diode conducting, active low |
| diode_b_lo_n | input | 1 | Leg B lower diode conducting, active low |
| gate_a_hi | output | 1 | Gate, leg A upper switch |
| gate_a_lo | output | 1 | Gate, leg A lower switch |
| gate_b_hi | output | 1 | Gate, leg B upper switch |
| gate_b_lo | output | 1 | Gate, leg B lower switch |
| fault | output | 1 | Sticky same-leg double-conduction fault |

## Verification
A PWM change reaches the gates one edge later, while a diode flag change needs eight edges: two for synchronizing, three for filtering, then one each for the filtered flag, the polarity register and the gate register. The bench changes inputs on falling edges and samples on later falling edges. Table vectors wait twelve cycles after a diode change and one cycle after a PWM flip. A directed test samples at exactly seven and eight edges to pin the diode-path latency. The glitch tests hold a flag for two and for three cycles, then wait well past the latency before sampling.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_POS  = 2'b01,
    POL_NEG  = 2'b10
  } pol_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_gates_t;

  // Polarity update from filtered conduction votes; holds on clash or tie.
  function automatic pol_e next_polarity(input logic vote_pos, input logic vote_neg,
                                         input logic clash, input pol_e cur);
    if (clash || (vote_pos == vote_neg)) return cur;
    return vote_pos ? POL_POS : POL_NEG;
  endfunction

  // Gate pattern for one leg: current out of leg -> upper follows pwm,
  // current into leg -> lower follows inverted pwm.
  function automatic leg_gates_t leg_drive(input logic decided, input logic out_pos,
                                           input logic pwm);
    leg_gates_t g;
    g.hi = decided & out_pos & pwm;
    g.lo = decided & ~out_pos & ~pwm;
    return g;
  endfunction

endpackage

// File: rtl/hbg_flag_filter.sv
module hbg_flag_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_n,
  output logic conducting
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   agree_low;
  logic                   agree_high;
  logic                   window_agree;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], flag_n};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
    end
  end

  assign agree_low    = (hist_q == '0);
  assign agree_high   = &hist_q;
  assign window_agree = agree_low | agree_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          conducting <= 1'b0;
    else if (agree_low)  conducting <= 1'b1;
    else if (agree_high) conducting <= 1'b0;
  end

  // R7: the filtered flag moves only after a full agreeing window
  assert_filter_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conducting != $past(conducting)) |-> $past(window_agree));

endmodule

// File: rtl/hbg_polarity_tracker.sv
module hbg_polarity_tracker
  import hbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cond,      // [3]=A upper, [2]=A lower, [1]=B upper, [0]=B lower
  output logic [1:0] pol_code,
  output logic       fault
);

  localparam int A_HI = 3;
  localparam int A_LO = 2;
  localparam int B_HI = 1;
  localparam int B_LO = 0;

  pol_e pol_q, pol_d;
  logic leg_clash, vote_pos, vote_neg, no_evidence;

  assign leg_clash   = (cond[A_HI] & cond[A_LO]) | (cond[B_HI] & cond[B_LO]);
  assign no_evidence = ~|cond;
  assign vote_pos    = (cond[A_LO] & ~cond[A_HI]) | (cond[B_HI] & ~cond[B_LO]);
  assign vote_neg    = (cond[A_HI] & ~cond[A_LO]) | (cond[B_LO] & ~cond[B_HI]);

  always_comb pol_d = next_polarity(vote_pos, vote_neg, leg_clash, pol_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= POL_NONE;
      fault <= 1'b0;
    end else begin
      pol_q <= pol_d;
      if (leg_clash) fault <= 1'b1;
    end
  end

  assign pol_code = pol_q;

  // R6: polarity held while no diode conducts
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_evidence |=> (pol_q == $past(pol_q)));
  // R8: same-leg clash keeps polarity and raises fault
  assert_clash_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    leg_clash |=> (pol_q == $past(pol_q)) && fault);
  // R8: fault is sticky
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  // R9: cross-leg disagreement keeps polarity and fault
  assert_cross_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_pos && vote_neg && !leg_clash) |=>
      (pol_q == $past(pol_q)) && (fault == $past(fault)));

endmodule

// File: rtl/hbg_leg_driver.sv
module hbg_leg_driver
  import hbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic decided,
  input  logic out_pos,
  input  logic pwm,
  output logic gate_hi,
  output logic gate_lo
);

  leg_gates_t g_d;

  always_comb g_d = leg_drive(decided, out_pos, pwm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= g_d.hi;
      gate_lo <= g_d.lo;
    end
  end

  // R4: never both switches of a leg
  assert_single_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  // R1: no gating before a polarity exists
  assert_idle_undecided_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !decided |=> (!gate_hi && !gate_lo));

endmodule

// File: rtl/hbridge_polarity_gate.sv
module hbridge_polarity_gate
  import hbg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_a,
  input  logic pwm_b,
  input  logic diode_a_hi_n,
  input  logic diode_a_lo_n,
  input  logic diode_b_hi_n,
  input  logic diode_b_lo_n,
  output logic gate_a_hi,
  output logic gate_a_lo,
  output logic gate_b_hi,
  output logic gate_b_lo,
  output logic fault
);

  localparam int NUM_LEGS  = 2;
  localparam int NUM_FLAGS = 2 * NUM_LEGS;

  logic [NUM_FLAGS-1:0] flags_n;
  logic [NUM_FLAGS-1:0] cond;
  logic [1:0]           pol_code;
  logic                 decided;
  logic [NUM_LEGS-1:0]  leg_pos;
  logic [NUM_LEGS-1:0]  leg_pwm;
  logic [NUM_LEGS-1:0]  g_hi;
  logic [NUM_LEGS-1:0]  g_lo;

  assign flags_n = {diode_a_hi_n, diode_a_lo_n, diode_b_hi_n, diode_b_lo_n};

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    hbg_flag_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .flag_n(flags_n[f]), .conducting(cond[f]));
  end

  hbg_polarity_tracker u_track (
    .clk(clk), .rst_n(rst_n), .cond(cond), .pol_code(pol_code), .fault(fault));

  assign decided = (pol_code != POL_NONE);
  // index 1 = leg A, index 0 = leg B; leg B current is the negative of leg A
  assign leg_pos = {pol_code == POL_POS, pol_code == POL_NEG};
  assign leg_pwm = {pwm_a, pwm_b};

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    hbg_leg_driver u_leg (
      .clk(clk), .rst_n(rst_n), .decided(decided), .out_pos(leg_pos[l]),
      .pwm(leg_pwm[l]), .gate_hi(g_hi[l]), .gate_lo(g_lo[l]));
  end

  assign gate_a_hi = g_hi[1];
  assign gate_a_lo = g_lo[1];
  assign gate_b_hi = g_hi[0];
  assign gate_b_lo = g_lo[0];

  // R5: legs always steered to opposite sides
  assert_legs_opposite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_a_hi && gate_b_hi) && !(gate_a_lo && gate_b_lo));

endmodule

// File: tb/sim_hbridge_polarity_gate.sv
`timescale 1ns/1ps
module sim_hbridge_polarity_gate;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_a = 1'b0, pwm_b = 1'b0;
  logic [3:0] flags_n = 4'b1111;   // {a_hi_n, a_lo_n, b_hi_n, b_lo_n}
  logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, fault;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbridge_polarity_gate u0 (
    .clk(clk), .rst_n(rst_n), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .diode_a_hi_n(flags_n[3]), .diode_a_lo_n(flags_n[2]),
    .diode_b_hi_n(flags_n[1]), .diode_b_lo_n(flags_n[0]),
    .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo),
    .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo), .fault(fault));

  // pol: 0 undecided, 1 current out of leg A, 2 current into leg A
  function automatic logic [3:0] model(input int pol, input logic pa, input logic pb);
    case (pol)
      1:       return {pa, 1'b0, 1'b0, !pb};
      2:       return {1'b0, !pa, pb, 1'b0};
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [3:0] eg, input logic ef);
    logic [4:0] act, exp;
    act = {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, fault};
    exp = {eg, ef};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual gates/fault=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {req[3:0], flags_n[3:0], pwm_a, pwm_b, pol[1:0]}
  localparam int NV = 9;
  localparam logic [11:0] VEC [NV] = '{
    {4'd1, 4'b1111, 1'b1, 1'b1, 2'd0},  // R1 nothing decided yet
    {4'd2, 4'b1011, 1'b1, 1'b1, 2'd1},  // R2 leg A lower diode
    {4'd6, 4'b1111, 1'b0, 1'b0, 2'd1},  // R6 hold positive
    {4'd3, 4'b0111, 1'b0, 1'b1, 2'd2},  // R3 leg A upper diode
    {4'd6, 4'b1111, 1'b1, 1'b1, 2'd2},  // R6 hold negative
    {4'd5, 4'b1101, 1'b1, 1'b0, 2'd1},  // R5 leg B upper diode -> positive
    {4'd5, 4'b1110, 1'b0, 1'b0, 2'd2},  // R5 leg B lower diode -> negative
    {4'd9, 4'b1010, 1'b1, 1'b1, 2'd2},  // R9 cross-leg disagreement holds
    {4'd2, 4'b1001, 1'b1, 1'b0, 2'd1}   // R2 both legs agree positive
  };

  initial begin
    cycles(3);
    check("R1 during reset", 4'b0000, 1'b0);
    rst_n = 1'b1;
    cycles(2);
    check("R1 after reset", 4'b0000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      int pol;
      string tag;
      v = VEC[i];
      pol = int'(v[1:0]);
      flags_n = v[7:4]; pwm_a = v[3]; pwm_b = v[2];
      cycles(12);
      tag = $sformatf("vector %0d (R%0d)", i, v[11:8]);
      check(tag, model(pol, pwm_a, pwm_b), 1'b0);
      pwm_a = !pwm_a; pwm_b = !pwm_b;
      cycles(1);
      tag = $sformatf("vector %0d pwm flip R10", i);
      check(tag, model(pol, pwm_a, pwm_b), 1'b0);
    end

    // R7 latency: positive -> negative, exactly 8 edges
    pwm_a = 1'b1; pwm_b = 1'b1;
    cycles(2);
    flags_n = 4'b0111;
    cycles(7);
    check("R7 latency edge 7", model(1, 1'b1, 1'b1), 1'b0);
    cycles(1);
    check("R7 latency edge 8", model(2, 1'b1, 1'b1), 1'b0);
    flags_n = 4'b1111;
    cycles(12);
    // R7 two-cycle glitch rejected
    flags_n = 4'b1011;
    cycles(2);
    flags_n = 4'b1111;
    cycles(12);
    check("R7 glitch of 2 ignored", model(2, 1'b1, 1'b1), 1'b0);
    // R7 three-cycle pulse accepted
    flags_n = 4'b1011;
    cycles(3);
    flags_n = 4'b1111;
    cycles(12);
    check("R7 pulse of 3 accepted", model(1, 1'b1, 1'b1), 1'b0);

    // R8 same-leg clash
    flags_n = 4'b0011;
    cycles(12);
    check("R8 clash holds and faults", model(1, 1'b1, 1'b1), 1'b1);
    flags_n = 4'b1111;
    cycles(12);
    check("R8 fault sticky", model(1, 1'b1, 1'b1), 1'b1);
    flags_n = 4'b0111;
    cycles(12);
    check("R8 polarity still tracks", model(2, 1'b1, 1'b1), 1'b1);

    // R1 reset clears everything
    flags_n = 4'b1111;
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(12);
    check("R1 re-reset", 4'b0000, 1'b0);
    pwm_a = 1'b0; pwm_b = 1'b0;
    cycles(1);
    check("R1 undecided pwm low", 4'b0000, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule